// File: doc/BRIEF.md
# GPIO Controller with Per-Line Interrupt Triggers

This block is a sixteen-line general-purpose I/O peripheral with a single-cycle register interface. Software drives pad levels through an output-data register and chooses each pad's direction through a direction register. Every pad input passes through a two-flop synchroniser. The synchronised value can be read back, and it feeds a per-line trigger detector. The detector is configured by a 3-bit style code per line. Detected events latch into a status register that software clears by writing ones.

The lower thirteen status bits go out as active-high level interrupt requests toward an interrupt controller. Lines 13 to 15 still latch status but have no request output. Two 32-bit select words, for clock routing and debounce choice, are held for software and have no effect on line behaviour. The register port is a plain control interface: a write or read happens in the cycle its enable is high. There is no back-pressure. Read data is combinational from the address.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset: output data reads 0, direction reads 0x0000FFFF (all lines inputs, so `pad_drive_en` is 0), status reads 0, both style words read 0, both select words read 0, and `irq_out` is 0.
- R2: `pad_out` always equals the output-data register (word 0). In the direction register (word 1), bit n = 1 makes line n an input with its driver off (`pad_drive_en[n]` = 0). Bit n = 0 drives it (`pad_drive_en[n]` = 1).
- R3: The input register (word 2) returns the pad levels delayed by two clock edges: a pad change made before edge k is first readable after edge k+1.
- R4: A write to the status register (word 3) clears each bit whose write-data bit is 1 and leaves bits written with 0 unchanged.
- R5: When a trigger event and a write-one clear hit the same status bit in the same cycle, the bit stays set. A level style therefore sets its bit again on every cycle while the level holds.
- R6: Style word 4 holds lines 0–7 and style word 5 holds lines 8–15. Line k within a word uses bits [3k+2:3k]. Bits 31:24 of both words read 0. The codes are: 0 = level high, 1 = level low, 2 = rising edge, 3 = falling edge, 4 = any transition. Codes 5–7 never set status.
- R7: Edge styles compare the synchronised level with its value one cycle earlier. A pad change made before edge k sets the status bit at edge k+2, and the bit is not set again while the pad stays still.
- R8: `irq_out[n]` equals status bit n for lines 0–12. Status bits 13–15 latch and read back but drive no output.
- R9: The clock-select word (word 6) and the debounce-select word (word 7) store and return all 32 bits. Lines 14 and 15 keep behaving as ordinary GPIO lines whatever those words hold.
- R10: Word addresses are 0 output data, 1 direction, 2 input, 3 status, 4 and 5 styles, 6 clock select and 7 debounce select. Writes to word 2 are ignored. `reg_rdata` is 0 whenever `reg_re` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read enable |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| pad_in | input | 16 | Asynchronous pad levels |
| pad_out | output | 16 | Levels to drive onto pads |
| pad_drive_en | output | 16 | Per-line pad driver enable, 1 = drive |
| irq_out | output | 13 | Level interrupt requests for lines 0–12 |

## Verification
Single rising and falling steps on one line at a time separate the two edge styles. They also show the three-edge latency from pad to status. A line set to any-transition is toggled both ways, which shows that both directions latch. A held low level under a level-low style, with a clear written while the level persists and again after it is gone, shows that set has priority over clear. Toggling a line that carries an unused code shows that codes 5–7 are inert. Holding a level high on line 14 shows that its status latches while every request output stays low.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [2:0] {
    TRIG_LVL_HI = 3'd0,
    TRIG_LVL_LO = 3'd1,
    TRIG_RISE   = 3'd2,
    TRIG_FALL   = 3'd3,
    TRIG_ANY    = 3'd4
  } trig_e;

  localparam int unsigned WRD_DOUT   = 0;
  localparam int unsigned WRD_DIR    = 1;
  localparam int unsigned WRD_PIN    = 2;
  localparam int unsigned WRD_STAT   = 3;
  localparam int unsigned WRD_STY0   = 4;
  localparam int unsigned WRD_CKSEL  = 6;
  localparam int unsigned WRD_DBSEL  = 7;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pad_i,
  output logic [NUM_LINES-1:0] cur_o,
  output logic [NUM_LINES-1:0] old_o
);

  logic [NUM_LINES-1:0] meta_q;
  logic [NUM_LINES-1:0] cur_q;
  logic [NUM_LINES-1:0] old_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      old_q  <= '0;
    end else begin
      meta_q <= pad_i;
      cur_q  <= meta_q;
      old_q  <= cur_q;
    end
  end

  assign cur_o = cur_q;
  assign old_o = old_q;

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int STYLE_W   = 3
) (
  input  logic [NUM_LINES*STYLE_W-1:0] style_i,
  input  logic [NUM_LINES-1:0]         cur_i,
  input  logic [NUM_LINES-1:0]         old_i,
  output logic [NUM_LINES-1:0]         hit_o
);

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    logic [STYLE_W-1:0] code;
    logic               hit;

    assign code = style_i[n*STYLE_W +: STYLE_W];

    always_comb begin
      unique case (code)
        TRIG_LVL_HI: hit = cur_i[n];
        TRIG_LVL_LO: hit = ~cur_i[n];
        TRIG_RISE:   hit = cur_i[n] & ~old_i[n];
        TRIG_FALL:   hit = ~cur_i[n] & old_i[n];
        TRIG_ANY:    hit = cur_i[n] ^ old_i[n];
        default:     hit = 1'b0;
      endcase
    end

    always_comb begin
      if (hit && (code == TRIG_RISE || code == TRIG_FALL || code == TRIG_ANY)) begin
        AST_EDGE_NEEDS_CHANGE: assert (cur_i[n] != old_i[n]) else $error("edge hit without change"); // R7
      end
    end

    assign hit_o[n] = hit;
  end

endmodule

// File: rtl/gpio_status.sv
module gpio_status #(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] set_i,
  input  logic [NUM_LINES-1:0] clr_i,
  output logic [NUM_LINES-1:0] stat_o
);

  logic [NUM_LINES-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_i) | set_i;
  end

  assign stat_o = stat_q;

  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((stat_o & $past(clr_i & ~set_i)) == '0)) else $error("clear failed"); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((stat_o & $past(set_i)) == $past(set_i))) else $error("set lost"); // R5
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0 && clr_i == '0) |=> $stable(stat_o)) else $error("status drifted"); // R4

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES     = 16,
  parameter int NUM_IRQ       = 13,
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 3,
  parameter int STYLE_W       = 3,
  parameter int LINES_PER_STY = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_LINES-1:0] pad_in,
  output logic [NUM_LINES-1:0] pad_out,
  output logic [NUM_LINES-1:0] pad_drive_en,
  output logic [NUM_IRQ-1:0]   irq_out
);

  localparam int STY_BITS = LINES_PER_STY * STYLE_W;
  localparam int NUM_STY  = NUM_LINES / LINES_PER_STY;
  localparam int PAD_W    = DATA_W - NUM_LINES;

  logic [NUM_LINES-1:0]         dout_q, dir_q;
  logic [DATA_W-1:0]            cksel_q, dbsel_q;
  logic [NUM_LINES*STYLE_W-1:0] style_flat;
  logic [NUM_LINES-1:0]         cur, old, hit, clr, stat;
  logic [DATA_W-1:0]            rd_mux;

  function automatic logic hit_addr(input logic [ADDR_W-1:0] a, input int unsigned w);
    return a == ADDR_W'(w);
  endfunction

  // Plain configuration words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      dir_q   <= '1;
      cksel_q <= '0;
      dbsel_q <= '0;
    end else if (reg_we) begin
      if (hit_addr(reg_addr, WRD_DOUT))  dout_q  <= reg_wdata[NUM_LINES-1:0];
      if (hit_addr(reg_addr, WRD_DIR))   dir_q   <= reg_wdata[NUM_LINES-1:0];
      if (hit_addr(reg_addr, WRD_CKSEL)) cksel_q <= reg_wdata;
      if (hit_addr(reg_addr, WRD_DBSEL)) dbsel_q <= reg_wdata;
    end
  end

  // Style words, one per group of lines
  for (genvar s = 0; s < NUM_STY; s++) begin : g_sty
    logic [STY_BITS-1:0] sty_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sty_q <= '0;
      else if (reg_we && hit_addr(reg_addr, WRD_STY0 + s)) sty_q <= reg_wdata[STY_BITS-1:0];
    end
    assign style_flat[s*STY_BITS +: STY_BITS] = sty_q;
  end

  gpio_in_sync #(.NUM_LINES(NUM_LINES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pad_i (pad_in),
    .cur_o (cur),
    .old_o (old)
  );

  gpio_trig_detect #(.NUM_LINES(NUM_LINES), .STYLE_W(STYLE_W)) u_trig (
    .style_i (style_flat),
    .cur_i   (cur),
    .old_i   (old),
    .hit_o   (hit)
  );

  assign clr = (reg_we && hit_addr(reg_addr, WRD_STAT)) ? reg_wdata[NUM_LINES-1:0] : '0;

  gpio_status #(.NUM_LINES(NUM_LINES)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (hit),
    .clr_i  (clr),
    .stat_o (stat)
  );

  // Read path
  always_comb begin
    rd_mux = '0;
    if (hit_addr(reg_addr, WRD_DOUT))       rd_mux = {{PAD_W{1'b0}}, dout_q};
    else if (hit_addr(reg_addr, WRD_DIR))   rd_mux = {{PAD_W{1'b0}}, dir_q};
    else if (hit_addr(reg_addr, WRD_PIN))   rd_mux = {{PAD_W{1'b0}}, cur};
    else if (hit_addr(reg_addr, WRD_STAT))  rd_mux = {{PAD_W{1'b0}}, stat};
    else if (hit_addr(reg_addr, WRD_CKSEL)) rd_mux = cksel_q;
    else if (hit_addr(reg_addr, WRD_DBSEL)) rd_mux = dbsel_q;
    else begin
      for (int s = 0; s < NUM_STY; s++) begin
        if (hit_addr(reg_addr, WRD_STY0 + s)) rd_mux[STY_BITS-1:0] = style_flat[s*STY_BITS +: STY_BITS];
      end
    end
  end

  assign reg_rdata    = reg_re ? rd_mux : '0;
  assign pad_out      = dout_q;
  assign pad_drive_en = ~dir_q;
  assign irq_out      = stat[NUM_IRQ-1:0];

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && hit_addr(reg_addr, WRD_DIR)) |=> (pad_drive_en == ~$past(reg_wdata[NUM_LINES-1:0]))) else $error("direction"); // R2
  AST_STY_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && (hit_addr(reg_addr, WRD_STY0) || hit_addr(reg_addr, WRD_STY0 + 1))) |-> (reg_rdata[DATA_W-1:STY_BITS] == '0)) else $error("style pad bits"); // R6
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_re |-> (reg_rdata == '0)) else $error("idle read"); // R10

endmodule

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;

  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0, re = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [15:0] pad = '0;
  logic [31:0] rdata;
  logic [15:0] pout, pdrv;
  logic [12:0] irq;

  int total = 0, bad = 0;
  logic [31:0] v;

  gpio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_re(re), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .pad_in(pad), .pad_out(pout),
    .pad_drive_en(pdrv), .irq_out(irq)
  );

  always #4 clk = ~clk;

  // Behavioural reference
  bit [15:0] m_out = 0, m_oe = 16'hFFFF, m_s1 = 0, m_s2 = 0, m_prev = 0, m_stat = 0;
  bit [23:0] m_sty [2] = '{0, 0};
  bit [31:0] m_ck = 0, m_db = 0;

  function automatic bit m_hit(int code, bit c, bit o);
    case (code)
      0: return c;
      1: return !c;
      2: return c && !o;
      3: return !c && o;
      4: return c != o;
      default: return 0;
    endcase
  endfunction

  function automatic bit [31:0] m_read(int a);
    case (a)
      0: return {16'h0, m_out};
      1: return {16'h0, m_oe};
      2: return {16'h0, m_s2};
      3: return {16'h0, m_stat};
      4: return {8'h0, m_sty[0]};
      5: return {8'h0, m_sty[1]};
      6: return m_ck;
      default: return m_db;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_out = 0; m_oe = 16'hFFFF; m_s1 = 0; m_s2 = 0; m_prev = 0; m_stat = 0;
      m_sty[0] = 0; m_sty[1] = 0; m_ck = 0; m_db = 0;
    end else begin
      bit [15:0] ns;
      ns = m_stat;
      if (we && addr == 3) ns = ns & ~wdata[15:0];
      for (int i = 0; i < 16; i++)
        if (m_hit((int'(m_sty[i/8]) >> (3*(i%8))) & 7, m_s2[i], m_prev[i])) ns[i] = 1'b1;
      if (we) case (addr)
        0: m_out = wdata[15:0];
        1: m_oe = wdata[15:0];
        4: m_sty[0] = wdata[23:0];
        5: m_sty[1] = wdata[23:0];
        6: m_ck = wdata;
        7: m_db = wdata;
        default: ;
      endcase
      m_stat = ns; m_prev = m_s2; m_s2 = m_s1; m_s1 = pad;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Clock-by-clock comparison against the reference
  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      chk("R2 pad_out", {16'h0, pout}, {16'h0, m_out});
      chk("R2 drive", {16'h0, pdrv}, {16'h0, ~m_oe});
      chk("R8 irq", {19'h0, irq}, {19'h0, m_stat[12:0]});
      chk("R10 rdata", rdata, re ? m_read(int'(addr)) : 32'h0);
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(logic [2:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask
  task automatic rd(logic [2:0] a, output logic [31:0] d);
    re = 1'b1; addr = a;
    #1 d = rdata;
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(2);
    // R1 reset values
    rd(0, v); chk("R1 dout", v, 32'h0);
    rd(1, v); chk("R1 dir", v, 32'h0000FFFF);
    rd(3, v); chk("R1 stat", v, 32'h0);
    rd(4, v); chk("R1 sty0", v, 32'h0);
    rd(5, v); chk("R1 sty1", v, 32'h0);
    rd(6, v); chk("R1 cksel", v, 32'h0);
    rd(7, v); chk("R1 dbsel", v, 32'h0);
    chk("R1 drive", {16'h0, pdrv}, 32'h0);
    chk("R1 irq", {19'h0, irq}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    step();

    // R6 all lines inert, upper bits zero
    wr(4, 32'hFFFFFFFF); wr(5, 32'hFFFFFFFF);
    rd(4, v); chk("R6 sty0 upper", v, 32'h00FFFFFF);
    rd(5, v); chk("R6 sty1 upper", v, 32'h00FFFFFF);

    // R2 output and direction
    wr(0, 32'h0000A5A5); wr(1, 32'h00000F0F);
    chk("R2 pad_out", {16'h0, pout}, 32'h0000A5A5);
    chk("R2 drive", {16'h0, pdrv}, 32'h0000F0F0);

    // R3 synchroniser latency
    step(); pad = 16'h1234;
    step(); rd(2, v); chk("R3 one edge", v, 32'h0);
    step(); rd(2, v); chk("R3 two edges", v, 32'h1234);
    rd(3, v); chk("R6 codes 7 inert", v, 32'h0);
    step(); pad = 16'h0000; step(4);

    // R7 rising edge on line 2
    wr(4, 32'h00FFFEBF);
    step(); pad = 16'h0004;
    step(2); rd(3, v); chk("R7 rise early", v, 32'h0);
    step(); rd(3, v); chk("R7 rise latch", v, 32'h0004);
    chk("R8 irq line2", {19'h0, irq}, 32'h4);
    step(3); rd(3, v); chk("R7 edge no repeat", v, 32'h0004);
    // R4 write-one-to-clear
    wr(3, 32'h0); rd(3, v); chk("R4 zero no effect", v, 32'h0004);
    wr(3, 32'h4); rd(3, v); chk("R4 one clears", v, 32'h0);
    step(2); rd(3, v); chk("R7 stays clear", v, 32'h0);

    // Falling edge on line 9
    step(); pad = 16'h0204; step(4);
    wr(5, 32'h00FFFFDF);
    step(); pad = 16'h0004;
    step(3); rd(3, v); chk("R6 fall line9", v, 32'h0200);
    chk("R8 irq line9", {19'h0, irq}, 32'h200);
    wr(3, 32'h200);

    // Any transition on line 12
    wr(5, 32'h00FFCFDF);
    step(); pad = 16'h1004;
    step(3); rd(3, v); chk("R6 any rise", v, 32'h1000);
    wr(3, 32'h1000); rd(3, v); chk("R4 clear any", v, 32'h0);
    step(); pad = 16'h0004;
    step(3); rd(3, v); chk("R6 any fall", v, 32'h1000);
    wr(3, 32'h1000);

    // R5 level low on line 0 with clear while held
    wr(4, 32'h00FFFEB9);
    step(); rd(3, v); chk("R5 level sets", v, 32'h0001);
    wr(3, 32'h1); rd(3, v); chk("R5 set beats clear", v, 32'h0001);
    step(); pad = 16'h0005;
    step(3); wr(3, 32'h1); rd(3, v); chk("R5 clear after level", v, 32'h0);

    // R8 line 14 level high latches without request
    wr(5, 32'h00E3CFDF);
    step(); pad = 16'h4005;
    step(3); rd(3, v); chk("R8 line14 status", v, 32'h4000);
    chk("R8 no irq upper", {19'h0, irq}, 32'h0);
    step(); pad = 16'h0005; step(3);
    wr(3, 32'h4000); rd(3, v); chk("R8 line14 cleared", v, 32'h0);

    // R6 code 5 on line 3 is inert
    wr(4, 32'h00FFFAB9);
    step(); pad = 16'h000D; step(3);
    pad = 16'h0005; step(3);
    rd(3, v); chk("R6 code5 inert", v, 32'h0);

    // R9 select words, lines 14/15 still GPIO
    wr(6, 32'hDEADBEEF); wr(7, 32'h12345678);
    rd(6, v); chk("R9 cksel", v, 32'hDEADBEEF);
    rd(7, v); chk("R9 dbsel", v, 32'h12345678);
    wr(0, 32'h0000C000); wr(1, 32'h0);
    chk("R9 upper pads out", {16'h0, pout}, 32'h0000C000);
    chk("R9 upper pads drive", {16'h0, pdrv}, 32'h0000FFFF);

    // R10 input word read-only, idle read zero
    wr(2, 32'h0000FFFF); rd(2, v); chk("R10 pin read-only", v, 32'h0005);
    re = 1'b0; #1 chk("R10 idle zero", rdata, 32'h0);
    step(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule